// File: doc/BRIEF.md
# Frame-Synchronous Staged Control Register Bank

This block is the configuration register bank of a video correction core. It sits on a 32-bit synchronous memory-mapped bus with one read port and one write port. Its read-only configuration words report fixed build parameters. Its writable control words set the bypass flag, the colour-mosaic phase, the zone geometry and the ramp increments.

Writes to control words land in a shadow copy. The datapath never sees that copy directly. Software writes a non-zero value to the commit word, which marks a commit as pending. On the next frame-start pulse the whole shadow set moves into the active set in a single clock edge, and the pending flag drops. In this way a frame is never processed with a half-updated setup. A status word shows whether the core is running and whether a commit is still waiting. Readback of the control words exists only in builds with the debug option set.

Top module: `stage_regbank`

## Requirements
- R1: After reset, every active output, the shadow set, the pending flag and `rdata_o` are 0.
- R2: A read sampled with `re_i` high returns its data in `rdata_o` after that clock edge, and `rdata_o` holds its value while `re_i` is low. The configuration words return fixed values: 0x00 identifier (`CORE_ID`), 0x04 reduced-mode flag (always 1), 0x08 debug flag (`DEBUG_EN`), 0x0C bits per sample, 0x10 maximum width, 0x14 maximum height.
- R3: A write to a control word (0x48 control, 0x4C zone width, 0x50 zone height, 0x54 zone columns, 0x58 zone rows, 0x5C horizontal ramp, 0x60 vertical ramp) changes only the shadow copy. The active outputs do not change until a commit is applied.
- R4: A write of non-zero data to the commit word 0x44 sets the pending flag on the next edge. A write of zero to that word has no effect.
- R5: A frame-start pulse that arrives while a commit is pending copies the whole shadow set to the active outputs on that edge and clears the pending flag. A frame-start pulse with nothing pending changes nothing.
- R6: If a commit write and a frame-start pulse arrive in the same cycle, a copy happens only if a commit was already pending, and the pending flag is set after that edge either way.
- R7: Status word 0x40 reads bit 0 = `running_i` and bit 1 = pending flag, with bits 31:2 zero.
- R8: Field widths: control bit 0 is bypass, control bits 2:1 are the mosaic phase, the zone words use bits 15:0, and the ramp words use bits 21:0. Higher written bits are dropped and read back as 0.
- R9: With `DEBUG_EN`=1 the control words read back their shadow values. With `DEBUG_EN`=0 they read 0. The commit word always reads 0.
- R10: Reserved word addresses, and any address whose bits 1:0 are not zero, read 0. Writes to these addresses and to the configuration and status words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Byte address |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| frame_start_i | input | 1 | One-cycle frame boundary pulse from the datapath |
| running_i | input | 1 | Core is processing data |
| bypass_o | output | 1 | Active bypass flag |
| mosaic_phase_o | output | 2 | Active 2x2 colour-mosaic phase |
| zone_w_o | output | 16 | Active zone width in pixels |
| zone_h_o | output | 16 | Active zone height in lines |
| zone_cols_o | output | 16 | Active horizontal zone count |
| zone_rows_o | output | 16 | Active vertical zone count |
| ramp_h_o | output | 22 | Active horizontal ramp increment |
| ramp_v_o | output | 22 | Active vertical ramp increment |

## Verification
The assertions assume that `frame_start_i` is a pulse that is low while reset is asserted. They also assume that the bus strobes are driven only on a stable clock, so that a write and a read in the same cycle refer to the same address. The bench changes every input at the falling edge and raises at most one strobe per bus task. The only deliberate overlap of a commit write with a frame pulse is in the R6 scenarios, which are driven both with and without a commit already pending.

// File: rtl/stage_regbank_pkg.sv
package stage_regbank_pkg;
  localparam int unsigned NUM_RW      = 7;
  localparam int unsigned RW_BASE     = 18;   // word index of first control word (0x48)
  localparam int unsigned STATUS_WORD = 16;
  localparam int unsigned COMMIT_WORD = 17;
  localparam int unsigned CFG_ID      = 0;
  localparam int unsigned CFG_LITE    = 1;
  localparam int unsigned CFG_DBG     = 2;
  localparam int unsigned CFG_BPS     = 3;
  localparam int unsigned CFG_MAXW    = 4;
  localparam int unsigned CFG_MAXH    = 5;

  typedef enum int unsigned {
    FLD_CTRL = 0, FLD_ZONE_W, FLD_ZONE_H, FLD_ZONE_COLS, FLD_ZONE_ROWS, FLD_RAMP_H, FLD_RAMP_V
  } fld_e;

  function automatic int unsigned fld_w(input int unsigned idx);
    case (idx)
      FLD_CTRL:                                          return 3;
      FLD_ZONE_W, FLD_ZONE_H, FLD_ZONE_COLS, FLD_ZONE_ROWS: return 16;
      default:                                           return 22;
    endcase
  endfunction

  function automatic int unsigned fld_off(input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < idx; k++) acc += fld_w(k);
    return acc;
  endfunction

  localparam int unsigned FLAT_W = fld_off(NUM_RW);
endpackage

// File: rtl/stage_field.sv
module stage_field #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         copy_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   shadow_o <= '0;
    else if (wr_i) shadow_o <= wdata_i;
  end

  // copy sees pre-edge shadow: a same-cycle write waits for the next commit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     active_o <= '0;
    else if (copy_i) active_o <= shadow_o;
  end
endmodule

// File: rtl/stage_commit_ctl.sv
module stage_commit_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic commit_req_i,
  input  logic frame_start_i,
  output logic pending_o,
  output logic copy_o
);
  logic pend_q;

  assign copy_o    = pend_q & frame_start_i;
  assign pending_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= commit_req_i | (pend_q & ~frame_start_i);
  end
endmodule

// File: rtl/stage_rd_mux.sv
module stage_rd_mux
  import stage_regbank_pkg::*;
#(
  parameter int unsigned WORD_W   = 6,
  parameter bit          DEBUG_EN = 1'b1,
  parameter logic [31:0] CORE_ID  = 32'h5A17_0C03,
  parameter int unsigned PIX_BITS = 12,
  parameter int unsigned MAX_W    = 1920,
  parameter int unsigned MAX_H    = 1080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  logic              aligned_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              running_i,
  input  logic              pending_i,
  input  logic [FLAT_W-1:0] shadow_flat_i,
  output logic [31:0]       rdata_o
);
  logic [31:0] rw_val [NUM_RW];
  logic [31:0] rd_val;

  for (genvar g = 0; g < NUM_RW; g++) begin : g_rw
    localparam int unsigned W   = fld_w(g);
    localparam int unsigned OFF = fld_off(g);
    assign rw_val[g] = DEBUG_EN ? {{(32-W){1'b0}}, shadow_flat_i[OFF +: W]} : '0;
  end

  always_comb begin
    rd_val = '0;
    if (aligned_i) begin
      case (word_i)
        WORD_W'(CFG_ID):      rd_val = CORE_ID;
        WORD_W'(CFG_LITE):    rd_val = 32'd1;
        WORD_W'(CFG_DBG):     rd_val = {31'd0, DEBUG_EN};
        WORD_W'(CFG_BPS):     rd_val = 32'(PIX_BITS);
        WORD_W'(CFG_MAXW):    rd_val = 32'(MAX_W);
        WORD_W'(CFG_MAXH):    rd_val = 32'(MAX_H);
        WORD_W'(STATUS_WORD): rd_val = {30'd0, pending_i, running_i};
        default:              rd_val = '0;
      endcase
      for (int k = 0; k < NUM_RW; k++)
        if (word_i == WORD_W'(RW_BASE + k)) rd_val = rw_val[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= rd_val;
  end
endmodule

// File: rtl/stage_regbank.sv
module stage_regbank
  import stage_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter bit          DEBUG_EN = 1'b1,
  parameter logic [31:0] CORE_ID  = 32'h5A17_0C03,
  parameter int unsigned PIX_BITS = 12,
  parameter int unsigned MAX_W    = 1920,
  parameter int unsigned MAX_H    = 1080
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic              frame_start_i,
  input  logic              running_i,
  output logic              bypass_o,
  output logic [1:0]        mosaic_phase_o,
  output logic [15:0]       zone_w_o,
  output logic [15:0]       zone_h_o,
  output logic [15:0]       zone_cols_o,
  output logic [15:0]       zone_rows_o,
  output logic [21:0]       ramp_h_o,
  output logic [21:0]       ramp_v_o
);
  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              commit_req;
  logic              pend_w;
  logic              copy_w;
  logic [NUM_RW-1:0] wr_rw;
  logic [FLAT_W-1:0] sh_flat;
  logic [FLAT_W-1:0] act_flat;

  assign word       = addr_i[ADDR_W-1:2];
  assign aligned    = (addr_i[1:0] == 2'b00);
  assign commit_req = we_i & aligned & (word == WORD_W'(COMMIT_WORD)) & (|wdata_i);

  for (genvar g = 0; g < NUM_RW; g++) begin : g_fld
    localparam int unsigned W   = fld_w(g);
    localparam int unsigned OFF = fld_off(g);
    assign wr_rw[g] = we_i & aligned & (word == WORD_W'(RW_BASE + g));
    stage_field #(.W(W)) u_fld (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (wr_rw[g]),
      .copy_i   (copy_w),
      .wdata_i  (wdata_i[W-1:0]),
      .shadow_o (sh_flat[OFF +: W]),
      .active_o (act_flat[OFF +: W])
    );
  end

  stage_commit_ctl u_commit (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_req_i  (commit_req),
    .frame_start_i (frame_start_i),
    .pending_o     (pend_w),
    .copy_o        (copy_w)
  );

  stage_rd_mux #(
    .WORD_W   (WORD_W),
    .DEBUG_EN (DEBUG_EN),
    .CORE_ID  (CORE_ID),
    .PIX_BITS (PIX_BITS),
    .MAX_W    (MAX_W),
    .MAX_H    (MAX_H)
  ) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .re_i          (re_i),
    .aligned_i     (aligned),
    .word_i        (word),
    .running_i     (running_i),
    .pending_i     (pend_w),
    .shadow_flat_i (sh_flat),
    .rdata_o       (rdata_o)
  );

  localparam int unsigned O_CTRL = fld_off(FLD_CTRL);
  assign bypass_o       = act_flat[O_CTRL];
  assign mosaic_phase_o = act_flat[O_CTRL+1 +: 2];
  assign zone_w_o       = act_flat[fld_off(FLD_ZONE_W)    +: 16];
  assign zone_h_o       = act_flat[fld_off(FLD_ZONE_H)    +: 16];
  assign zone_cols_o    = act_flat[fld_off(FLD_ZONE_COLS) +: 16];
  assign zone_rows_o    = act_flat[fld_off(FLD_ZONE_ROWS) +: 16];
  assign ramp_h_o       = act_flat[fld_off(FLD_RAMP_H)    +: 22];
  assign ramp_v_o       = act_flat[fld_off(FLD_RAMP_V)    +: 22];
endmodule

// File: rtl/stage_regbank_chk.sv
module stage_regbank_chk
  import stage_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter bit          DEBUG_EN = 1'b1,
  parameter int unsigned FW       = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              we_i,
  input logic              re_i,
  input logic [31:0]       wdata_i,
  input logic [31:0]       rdata_o,
  input logic              frame_start_i,
  input logic              running_i,
  input logic              pending,
  input logic [FW-1:0]     act_flat
);
  logic commit_hit, status_hit, rw_hit;
  assign commit_hit = we_i && (int'(addr_i) == COMMIT_WORD*4) && (wdata_i != '0);
  assign status_hit = (int'(addr_i) == STATUS_WORD*4);
  assign rw_hit     = (addr_i[1:0] == 2'b00) && (int'(addr_i) >= RW_BASE*4)
                      && (int'(addr_i) < (RW_BASE+NUM_RW)*4);

  a_r4_commit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_hit |=> pending);

  a_r5_pend_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending && frame_start_i && !commit_hit |=> !pending);

  a_r3_active_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pending && frame_start_i) |=> $stable(act_flat));

  a_r7_status_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && status_hit |=> rdata_o == {30'd0, $past(pending), $past(running_i)});

  a_r2_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

  a_r9_no_debug_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (DEBUG_EN == 1'b0) && re_i && rw_hit |=> rdata_o == '0);
endmodule

bind stage_regbank stage_regbank_chk #(
  .ADDR_W   (ADDR_W),
  .DEBUG_EN (DEBUG_EN),
  .FW       (stage_regbank_pkg::FLAT_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .addr_i        (addr_i),
  .we_i          (we_i),
  .re_i          (re_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .frame_start_i (frame_start_i),
  .running_i     (running_i),
  .pending       (pend_w),
  .act_flat      (act_flat)
);

// File: tb/stage_regbank_tb.sv
module stage_regbank_tb;
  localparam int CLK_P = 10;
  localparam int ADDR_W = 8;
  localparam logic [31:0] ID = 32'hC0DE_1234;
  localparam int PB = 10, MW = 4096, MH = 2160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, fs = 1'b0, run = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0;

  logic [31:0] rdata, n_rdata;
  logic byp, n_byp;
  logic [1:0] ph, n_ph;
  logic [15:0] zw, zh, zc, zr, n_zw, n_zh, n_zc, n_zr;
  logic [21:0] rh, rv, n_rh, n_rv;

  always #(CLK_P/2) clk = ~clk;

  stage_regbank #(.ADDR_W(ADDR_W), .DEBUG_EN(1'b1), .CORE_ID(ID), .PIX_BITS(PB), .MAX_W(MW), .MAX_H(MH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re), .wdata_i(wdata),
    .rdata_o(rdata), .frame_start_i(fs), .running_i(run), .bypass_o(byp), .mosaic_phase_o(ph),
    .zone_w_o(zw), .zone_h_o(zh), .zone_cols_o(zc), .zone_rows_o(zr), .ramp_h_o(rh), .ramp_v_o(rv));

  stage_regbank #(.ADDR_W(ADDR_W), .DEBUG_EN(1'b0), .CORE_ID(ID), .PIX_BITS(PB), .MAX_W(MW), .MAX_H(MH)) u_nodbg (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re), .wdata_i(wdata),
    .rdata_o(n_rdata), .frame_start_i(fs), .running_i(run), .bypass_o(n_byp), .mosaic_phase_o(n_ph),
    .zone_w_o(n_zw), .zone_h_o(n_zh), .zone_cols_o(n_zc), .zone_rows_o(n_zr), .ramp_h_o(n_rh), .ramp_v_o(n_rv));

  int errs = 0, checks = 0;
  logic [31:0] sh [7];
  logic [31:0] act [7];
  bit pend = 1'b0;

  function automatic logic [31:0] msk(input int i);
    int w;
    w = (i == 0) ? 3 : ((i < 5) ? 16 : 22);
    return 32'((64'd1 << w) - 1);
  endfunction

  function automatic logic [31:0] out_val(input int i, input bit nd);
    case (i)
      0: return nd ? {29'd0, n_ph, n_byp} : {29'd0, ph, byp};
      1: return nd ? 32'(n_zw) : 32'(zw);
      2: return nd ? 32'(n_zh) : 32'(zh);
      3: return nd ? 32'(n_zc) : 32'(zc);
      4: return nd ? 32'(n_zr) : 32'(zr);
      5: return nd ? 32'(n_rh) : 32'(rh);
      default: return nd ? 32'(n_rv) : 32'(rv);
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [ADDR_W-1:0] a, input bit dbg);
    int w;
    w = int'(a[ADDR_W-1:2]);
    if (a[1:0] != 2'b00) return '0;
    case (w)
      0: return ID;
      1: return 32'd1;
      2: return {31'd0, dbg};
      3: return 32'(PB);
      4: return 32'(MW);
      5: return 32'(MH);
      16: return {30'd0, pend, run};
      default: return (w >= 18 && w < 25 && dbg) ? sh[w-18] : '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic check_act(input string req);
    for (int i = 0; i < 7; i++) begin
      chk(req, out_val(i, 1'b0), act[i]);
      chk(req, out_val(i, 1'b1), act[i]);
    end
  endtask

  task automatic model_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    int w;
    w = int'(a[ADDR_W-1:2]);
    if (a[1:0] == 2'b00) begin
      if (w >= 18 && w < 25) sh[w-18] = d & msk(w-18);
      if (w == 17 && d != '0) pend = 1'b1;
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
    model_wr(a, d);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d1, output logic [31:0] d2);
    @(negedge clk); addr = a; re = 1'b1;
    @(negedge clk); re = 1'b0;
    d1 = rdata; d2 = n_rdata;
  endtask

  task automatic frame();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    if (pend) begin
      for (int i = 0; i < 7; i++) act[i] = sh[i];
      pend = 1'b0;
    end
  endtask

  task automatic commit_with_frame();
    @(negedge clk); addr = 8'h44; wdata = 32'd1; we = 1'b1; fs = 1'b1;
    @(negedge clk); we = 1'b0; fs = 1'b0;
    if (pend) for (int i = 0; i < 7; i++) act[i] = sh[i];
    pend = 1'b1;
  endtask

  task automatic write_all(input logic [31:0] seed);
    for (int i = 0; i < 7; i++) wr(ADDR_W'(72 + 4*i), seed ^ (32'h1357_9BDF * (i + 1)));
  endtask

  initial begin
    #(CLK_P * 100000);
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [31:0] d1, d2;
    for (int i = 0; i < 7; i++) begin sh[i] = '0; act[i] = '0; end
    #(CLK_P * 3);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check_act("R1 reset outputs");
    chk("R1 reset rdata", rdata, 32'd0);
    chk("R1 reset rdata nodebug", n_rdata, 32'd0);
    rd(8'h40, d1, d2);
    chk("R1 reset status", d1, 32'd0);

    // R2 configuration words
    run = 1'b1;
    for (int w = 0; w < 6; w++) begin
      rd(ADDR_W'(w*4), d1, d2);
      chk("R2 config dbg", d1, exp_rd(ADDR_W'(w*4), 1'b1));
      chk("R2 config nodbg", d2, exp_rd(ADDR_W'(w*4), 1'b0));
    end
    // R2 hold while re low
    repeat (3) @(negedge clk);
    chk("R2 rdata hold", rdata, 32'(MH));

    // R7 status running bit
    rd(8'h40, d1, d2);
    chk("R7 status running", d1, 32'd1);
    run = 1'b0;
    rd(8'h40, d1, d2);
    chk("R7 status idle", d1, 32'd0);
    run = 1'b1;

    // R8 R9 R3 sweep with all-ones upper bits
    write_all(32'hFFFF_0000);
    for (int i = 0; i < 7; i++) begin
      rd(ADDR_W'(72 + 4*i), d1, d2);
      chk("R8 field mask readback", d1, sh[i]);
      chk("R9 nodebug reads 0", d2, 32'd0);
    end
    check_act("R3 shadow only");

    // R5 frame without commit
    frame();
    check_act("R5 frame no pending");

    // R4 commit of zero ignored, non-zero sets
    wr(8'h44, 32'd0);
    rd(8'h40, d1, d2);
    chk("R4 zero commit ignored", d1, {30'd0, 1'b0, 1'b1});
    wr(8'h44, 32'h8000_0000);
    rd(8'h40, d1, d2);
    chk("R4 commit pending", d1, {30'd0, 1'b1, 1'b1});
    rd(8'h44, d1, d2);
    chk("R9 commit word reads 0", d1, 32'd0);
    check_act("R3 pending not applied");

    // R5 apply
    frame();
    check_act("R5 applied at frame");
    rd(8'h40, d1, d2);
    chk("R5 pending cleared", d1, 32'd1);

    // R6 commit and frame in same cycle, nothing pending
    write_all(32'h0F0F_A5A5);
    commit_with_frame();
    check_act("R6 no copy when not pending");
    rd(8'h40, d1, d2);
    chk("R6 pending set", d1, 32'd3);
    // R6 commit and frame together with pending
    write_all(32'h7777_1234);
    commit_with_frame();
    check_act("R6 copy when pending");
    rd(8'h40, d1, d2);
    chk("R6 pending stays", d1, 32'd3);
    frame();
    check_act("R5 second apply");

    // R10 ignored writes
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h49, 32'hFFFF_FFFF);
    wr(8'h45, 32'd1);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h40, d1, d2);
    chk("R10 misaligned commit ignored", d1, 32'd1);
    for (int w = 0; w < 64; w++) begin
      rd(ADDR_W'(w*4), d1, d2);
      chk("R10 map sweep dbg", d1, exp_rd(ADDR_W'(w*4), 1'b1));
      chk("R10 map sweep nodbg", d2, exp_rd(ADDR_W'(w*4), 1'b0));
    end
    for (int b = 1; b < 4; b++) begin
      rd(ADDR_W'(72 + b), d1, d2);
      chk("R10 misaligned read", d1, 32'd0);
    end
    frame();
    check_act("R10 outputs untouched");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule